// File: doc/BRIEF.md
# Processor Status Word with Register-Window Pointers

This block keeps the processor's 13-bit status word. The word holds four condition-code flags, a system-mode bit, the mode saved by the last call, an interrupt enable, and two 3-bit register-window pointers. One pointer selects the active window. The other marks the oldest window still held in the register file.

A procedure call moves the active-window pointer one step down, modulo 8. A return moves it one step up. A call also saves the system-mode bit into the saved-mode bit, and a return copies it back. When a step lands the active pointer on the oldest-window pointer, the block raises a one-cycle flag: overflow for a call, underflow for a return. Trap logic elsewhere uses these flags to spill or refill windows.

Software can read the word as a zero-padded 32-bit value and can load it in full from a 16-bit value. The ALU updates the condition codes through a qualified input.

Every update goes through one decoder, which picks exactly one operation for each cycle:

- `OP_HOLD`: nothing changes, apart from the condition codes when enabled.
- `OP_LOAD`: software write.
- `OP_CALL`: window push.
- `OP_RET`: window pop.

The priority is load first, then call, then return. The condition-code update runs alongside `OP_HOLD`, `OP_CALL` and `OP_RET`.

Top module: `psw_window_unit`

## Requirements
- R1: After reset the read value is 0x0000_0020: system mode set, every other field zero.
- R2: The read port gives the word zero-extended to 32 bits. The fields are:
  - bit 0: carry
  - bit 1: overflow
  - bit 2: negative
  - bit 3: zero
  - bit 4: saved mode
  - bit 5: system mode
  - bit 6: interrupt enable
  - bits 9:7: oldest-window pointer
  - bits 12:10: active-window pointer
- R3: With `wr_en_i` high, the word is loaded from `wr_data_i[12:0]` at the next edge. Bits 15:13 are ignored. A load overrides call, return and condition-code inputs in the same cycle.
- R4: A call (`call_i` high, no load) decrements the active-window pointer modulo 8 and copies system mode into saved mode.
- R5: A return (`ret_i` high, no load, no call) increments the active-window pointer modulo 8 and copies saved mode into system mode.
- R6: When call and return are both high, only the call takes effect.
- R7: `win_ovf_o` is high for exactly the one cycle after a call whose new active pointer equals the oldest-window pointer, and low otherwise.
- R8: `win_unf_o` is high for exactly the one cycle after a return whose new active pointer equals the oldest-window pointer, and low otherwise.
- R9: With `scc_i` high and no load, bits 3:0 take `cc_i`, where `cc_i[0]` is carry and `cc_i[3]` is zero. With `scc_i` low, the condition codes hold.
- R10: The oldest-window pointer and the interrupt enable change only through a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Load the whole word from `wr_data_i` |
| wr_data_i | input | 16 | Value to load; bits above 12 unused |
| call_i | input | 1 | Push a register window |
| ret_i | input | 1 | Pop a register window |
| scc_i | input | 1 | Enable condition-code update |
| cc_i | input | 4 | New flags: {zero, negative, overflow, carry} |
| rd_data_o | output | 32 | Status word, zero-padded |
| win_ovf_o | output | 1 | One-cycle window overflow flag |
| win_unf_o | output | 1 | One-cycle window underflow flag |

## Verification
The status word is one register level deep. A load, call, return or condition-code update therefore shows on `rd_data_o` right after the clock edge that captures it. The overflow and underflow flags come from their own register and are clocked on that same edge, so they show in the same cycle as the new pointer. Both flags must be low again one edge later.

The bench drives its inputs on falling edges and samples all outputs on the following falling edge, half a period after the capturing edge. It then applies one idle cycle and samples again to confirm that the flags have cleared.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int WIN_BITS = 3;
    localparam int CC_BITS  = 4;
    localparam int PSW_W    = CC_BITS + 3 + 2 * WIN_BITS;

    typedef logic [WIN_BITS-1:0] wptr_t;

    typedef struct packed {
        wptr_t      cwp;
        wptr_t      swp;
        logic       ien;
        logic       smode;
        logic       pmode;
        logic [CC_BITS-1:0] cc;
    } psw_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_CALL,
        OP_RET
    } psw_op_e;
endpackage

// File: rtl/psw_wptr_step.sv
module psw_wptr_step #(
    parameter int W        = 3,
    parameter bit DIR_DOWN = 1'b1
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] ref_i,
    output logic [W-1:0] nxt_o,
    output logic         hit_o
);
    generate
        if (DIR_DOWN) begin : g_down
            assign nxt_o = cur_i - W'(1);
        end else begin : g_up
            assign nxt_o = cur_i + W'(1);
        end
    endgenerate

    assign hit_o = (nxt_o == ref_i);
endmodule

// File: rtl/psw_cc_merge.sv
module psw_cc_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] cur_i,
    input  logic         scc_i,
    input  logic [N-1:0] new_i,
    output logic [N-1:0] nxt_o
);
    always_comb begin
        nxt_o = scc_i ? new_i : cur_i;
    end
endmodule

// File: rtl/psw_window_unit.sv
module psw_window_unit
    import psw_pkg::*;
#(
    parameter int RD_W = 32,
    parameter int WR_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [WR_W-1:0] wr_data_i,
    input  logic            call_i,
    input  logic            ret_i,
    input  logic            scc_i,
    input  logic [CC_BITS-1:0] cc_i,
    output logic [RD_W-1:0] rd_data_o,
    output logic            win_ovf_o,
    output logic            win_unf_o
);
    localparam int PAD_W = RD_W - PSW_W;
    localparam psw_t RST_VAL = '{cwp: '0, swp: '0, ien: 1'b0,
                                 smode: 1'b1, pmode: 1'b0, cc: '0};

    psw_t    psw_q, psw_d;
    psw_op_e op;
    wptr_t   dn_ptr, up_ptr;
    logic    dn_hit, up_hit;
    logic [CC_BITS-1:0] cc_nxt;
    logic    unused_wr_hi;

    assign unused_wr_hi = ^wr_data_i[WR_W-1:PSW_W];

    psw_wptr_step #(.W(WIN_BITS), .DIR_DOWN(1'b1)) u_step_dn (
        .cur_i(psw_q.cwp), .ref_i(psw_q.swp), .nxt_o(dn_ptr), .hit_o(dn_hit)
    );

    psw_wptr_step #(.W(WIN_BITS), .DIR_DOWN(1'b0)) u_step_up (
        .cur_i(psw_q.cwp), .ref_i(psw_q.swp), .nxt_o(up_ptr), .hit_o(up_hit)
    );

    psw_cc_merge #(.N(CC_BITS)) u_cc (
        .cur_i(psw_q.cc), .scc_i(scc_i), .new_i(cc_i), .nxt_o(cc_nxt)
    );

    // Operation select: load beats call beats return.
    always_comb begin
        if (wr_en_i)     op = OP_LOAD;
        else if (call_i) op = OP_CALL;
        else if (ret_i)  op = OP_RET;
        else             op = OP_HOLD;
    end

    always_comb begin
        psw_d = psw_q;
        unique case (op)
            OP_LOAD: psw_d = psw_t'(wr_data_i[PSW_W-1:0]);
            OP_CALL: begin
                psw_d.cc    = cc_nxt;
                psw_d.cwp   = dn_ptr;
                psw_d.pmode = psw_q.smode;
            end
            OP_RET: begin
                psw_d.cc    = cc_nxt;
                psw_d.cwp   = up_ptr;
                psw_d.smode = psw_q.pmode;
            end
            OP_HOLD: psw_d.cc = cc_nxt;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psw_q <= RST_VAL;
        else        psw_q <= psw_d;
    end

    // Output register for the window flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_ovf_o <= 1'b0;
            win_unf_o <= 1'b0;
        end else begin
            win_ovf_o <= (op == OP_CALL) && dn_hit;
            win_unf_o <= (op == OP_RET)  && up_hit;
        end
    end

    assign rd_data_o = {{PAD_W{1'b0}}, psw_q};

    AST_CALL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !wr_en_i) |=> (psw_q.cwp == $past(psw_q.cwp) - WIN_BITS'(1)
                                  && psw_q.pmode == $past(psw_q.smode))); // R4
    AST_RET_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !wr_en_i) |=> (psw_q.cwp == $past(psw_q.cwp) + WIN_BITS'(1)
                                            && psw_q.smode == $past(psw_q.pmode))); // R5
    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_ovf_o |=> !win_ovf_o); // R7
    AST_UNF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        win_unf_o |=> !win_unf_o); // R8
    AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!scc_i && !wr_en_i) |=> $stable(psw_q.cc)); // R9
    AST_SWP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(psw_q.swp) && $stable(psw_q.ien))); // R10
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_ovf_o && win_unf_o)); // R6
endmodule

// File: tb/psw_window_unit_tb_top.sv
module psw_window_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        call_i = 1'b0;
    logic        ret_i = 1'b0;
    logic        scc_i = 1'b0;
    logic [3:0]  cc_i = '0;
    logic [31:0] rd_data_o;
    logic        win_ovf_o, win_unf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [12:0] m;
    logic e_ovf, e_unf;

    always #10 clk = ~clk;

    psw_window_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .call_i(call_i), .ret_i(ret_i), .scc_i(scc_i), .cc_i(cc_i),
        .rd_data_o(rd_data_o), .win_ovf_o(win_ovf_o), .win_unf_o(win_unf_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected next state from the requirements.
    task automatic model(logic wr, logic [15:0] wd, logic cl, logic rt,
                         logic sc, logic [3:0] cc);
        int nc;
        e_ovf = 1'b0;
        e_unf = 1'b0;
        if (wr) begin
            m = wd[12:0];                       // R3
        end else begin
            if (sc) m[3:0] = cc;                // R9
            if (cl) begin                       // R4, R6
                nc = (int'(m[12:10]) + 7) % 8;
                e_ovf = (nc == int'(m[9:7]));   // R7
                m[4] = m[5];
                m[12:10] = 3'(nc);
            end else if (rt) begin              // R5
                nc = (int'(m[12:10]) + 1) % 8;
                e_unf = (nc == int'(m[9:7]));   // R8
                m[5] = m[4];
                m[12:10] = 3'(nc);
            end
        end
    endtask

    task automatic step(string req, logic wr, logic [15:0] wd, logic cl,
                        logic rt, logic sc, logic [3:0] cc);
        wr_en_i = wr; wr_data_i = wd; call_i = cl; ret_i = rt;
        scc_i = sc; cc_i = cc;
        model(wr, wd, cl, rt, sc, cc);
        @(posedge clk);
        @(negedge clk);
        chk(req, rd_data_o, {19'd0, m});
        chk({req, " R7"}, {31'd0, win_ovf_o}, {31'd0, e_ovf});
        chk({req, " R8"}, {31'd0, win_unf_o}, {31'd0, e_unf});
        wr_en_i = 1'b0; call_i = 1'b0; ret_i = 1'b0; scc_i = 1'b0;
        // Idle cycle: flags must drop, state holds.
        @(posedge clk);
        @(negedge clk);
        chk({req, " idle R7"}, {31'd0, win_ovf_o}, 32'd0);
        chk({req, " idle R8"}, {31'd0, win_unf_o}, 32'd0);
        chk({req, " idle R10"}, rd_data_o, {19'd0, m});
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", rd_data_o, 32'h0000_0020);
        chk("R1 ovf", {31'd0, win_ovf_o}, 32'd0);
        rst_n = 1'b1;
        m = 13'h0020;
        @(negedge clk);
        chk("R1 after release", rd_data_o, 32'h0000_0020);

        // R2, R4, R5, R7, R8: every pointer pair, both directions.
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 8; c++) begin
                for (int k = 0; k < 2; k++) begin
                    logic [15:0] wd;
                    wd = {3'b101, 3'(c), 3'(s), 1'(c), 1'(s), 1'(k ^ c), 4'(s + c)};
                    step("R3 load", 1'b1, wd, 1'b0, 1'b0, 1'b0, 4'h0);
                    chk("R2 cwp field", {29'd0, rd_data_o[12:10]}, 32'(c));
                    chk("R2 swp field", {29'd0, rd_data_o[9:7]}, 32'(s));
                    if (k == 0) step("R4 call", 1'b0, 16'h0, 1'b1, 1'b0, 1'(s & 1), 4'(c ^ s));
                    else        step("R5 ret",  1'b0, 16'h0, 1'b0, 1'b1, 1'(c & 1), 4'(c + 3));
                end
            end
        end

        // R9: condition-code sweep with and without enable.
        for (int v = 0; v < 16; v++) begin
            step("R9 scc on",  1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 4'(v));
            step("R9 scc off", 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 4'(~v));
        end

        // R6: call and return together.
        step("R3 load", 1'b1, 16'h0C90, 1'b0, 1'b0, 1'b0, 4'h0);
        step("R6 both", 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 4'h0);
        // R3: load overrides call/ret/cc, upper bits ignored.
        step("R3 priority", 1'b1, 16'hE5A5, 1'b1, 1'b1, 1'b1, 4'hF);
        // R10: repeated calls wrap around, swp and ien untouched.
        for (int i = 0; i < 9; i++) step("R10 wrap", 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 4'h0);
        for (int i = 0; i < 9; i++) step("R10 unwrap", 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 4'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule